// File: doc/BRIEF.md
# Sub-sampling column readout sequencer

This block produces, at the full pixel clock, the sequence of column indices to read for one image row. Internally a one-hot pointer walks across column pairs and moves once every two clocks. Each pointer position stands for a lower (even) column on lane A and an upper (odd) column on lane B. The two lanes are interleaved into a single stream of column indices, one per clock.

A sync pulse loads the pointer at a programmed start pair and latches the window controls. In full-resolution mode every column is read. In sub-sample mode the pointer jumps two positions per step and reads two columns out of each aligned group of four. Two swap controls choose which two columns those are. The window ends after a programmed number of output pixels, or at the right edge of the row if that comes first. The last index is marked with an end flag. The sequencer then stays idle until the next sync.

Top module: `col_subsample_seq`

## Requirements
- R1: While reset is low and on the first cycle after it, `valid_o` and `last_o` are 0 and `col_o` is 0.
- R2: While `sync_i` is high, `valid_o` stays 0. The first index of a window appears on the cycle after the first rising clock edge at which `sync_i` is low.
- R3: With `sub_en_i`=0, the window emits consecutive columns one per clock, starting at column 2×`start_pair_i` and ascending by one each clock.
- R4: With `sub_en_i`=1 and neither swap set, each group of four columns 4k..4k+3 yields columns 4k and 4k+1, in that order.
- R5: With `sub_en_i`=1 and only `swap12_i` set, each group yields columns 4k and 4k+2.
- R6: With `sub_en_i`=1 and only `swap30_i` set, each group yields columns 4k+1 and 4k+3.
- R7: With `sub_en_i`=1 and both swaps set, each group yields columns 4k+2 and 4k+3.
- R8: With `sub_en_i`=0, the swap inputs have no effect on the index stream.
- R9: In sub-sample mode, bit 0 of `start_pair_i` is ignored, so an odd start pair p begins at pair p−1.
- R10: A window of `width_i`=W emits exactly W valid indices. `last_o` is high with the W-th index only, and `valid_o` stays 0 from then until the next sync.
- R11: If the row's last column (NUM_COLS−1) is reached before W indices, the window ends there with `last_o` high.
- R12: A sync with `width_i`=0, or with a start pair at or beyond NUM_COLS/2, produces no valid index.
- R13: Start, width, sub-sample and swap inputs are latched only at a sync edge. Changing them during a window has no effect on that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_i | input | 1 | Load start position and latch window controls |
| start_pair_i | input | PAIR_W (10) | Start pointer position (column pair index) |
| width_i | input | CNT_W (12) | Number of output pixels in the window |
| sub_en_i | input | 1 | Sub-sample enable |
| swap12_i | input | 1 | Swap control moving the second read to offset 2 |
| swap30_i | input | 1 | Swap control shifting reads toward the upper offsets |
| col_o | output | COL_W (11) | Column index |
| valid_o | output | 1 | `col_o` is a column to read |
| last_o | output | 1 | Final column of the window |

## Verification
Some properties are checked on every cycle, whatever the stimulus:
- no index appears the cycle after a sync;
- the end flag only occurs together with a valid index and is followed by idle;
- indices stay inside the row;
- full-resolution indices advance by exactly one;
- sub-sampled indices climb by one to three columns.

Other behaviour can only be shown by the bench's directed scenarios, because it needs the programmed controls as a reference. This covers the exact column set chosen by each of the eight control combinations, the odd-start alignment, window length against the row edge, empty windows, and the latching of controls at sync.

// File: rtl/col_seq_pkg.sv
// Package: shared types and the group-offset rule for the column sequencer.
// Assumes groups of four columns aligned to multiples of four in sub-sample mode.
package col_seq_pkg;

    // Lane served in the current clock of a pointer step.
    typedef enum logic {
        LANE_A = 1'b0,
        LANE_B = 1'b1
    } lane_t;

    // Window controls latched at sync.
    typedef struct packed {
        logic sub;
        logic s12;
        logic s30;
    } rd_mode_t;

    // Offset inside a group of four for the column emitted on a lane in sub-sample mode.
    function automatic logic [1:0] grp_offset(rd_mode_t m, lane_t ln);
        logic [1:0] off;
        case ({m.s12, m.s30})
            2'b00:   off = (ln == LANE_B) ? 2'd1 : 2'd0;
            2'b10:   off = (ln == LANE_B) ? 2'd2 : 2'd0;
            2'b01:   off = (ln == LANE_B) ? 2'd3 : 2'd1;
            default: off = (ln == LANE_B) ? 2'd3 : 2'd2;
        endcase
        return off;
    endfunction

endpackage

// File: rtl/col_ptr.sv
// Module: one-hot column-pair pointer.
// Loads a single one at the decoded start position, shifts upward by one or
// two positions per step, and encodes the current position as a binary index.
// Assumes at most one bit set (guaranteed by load decode and shift-out).
module col_ptr #(
    parameter int NUM_PAIRS = 640,
    localparam int PAIR_W = $clog2(NUM_PAIRS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [PAIR_W-1:0] start_i,
    input  logic              shift_i,
    input  logic              step2_i,
    output logic [PAIR_W-1:0] pos_o
);

    logic [NUM_PAIRS-1:0] ptr_q;
    logic [NUM_PAIRS-1:0] dec;
    logic [NUM_PAIRS-1:0] nxt1;
    logic [NUM_PAIRS-1:0] nxt2;

    // Per-position start decode and shifted images of the pointer.
    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pos
        assign dec[i] = (start_i == PAIR_W'(i));
        if (i >= 2) begin : g_hi
            assign nxt1[i] = ptr_q[i-1];
            assign nxt2[i] = ptr_q[i-2];
        end else if (i == 1) begin : g_one
            assign nxt1[i] = ptr_q[0];
            assign nxt2[i] = 1'b0;
        end else begin : g_zero
            assign nxt1[i] = 1'b0;
            assign nxt2[i] = 1'b0;
        end
    end

    // Pointer register: load one-hot on sync, else shift on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load_i) begin
            ptr_q <= dec;
        end else if (shift_i) begin
            ptr_q <= step2_i ? nxt2 : nxt1;
        end
    end

    // One-hot to binary encoder (OR of the indices of set bits).
    always_comb begin
        pos_o = '0;
        for (int i = 0; i < NUM_PAIRS; i++) begin
            if (ptr_q[i]) begin
                pos_o = pos_o | PAIR_W'(i);
            end
        end
    end

endmodule

// File: rtl/col_lane_map.sv
// Module: maps pointer position, lane and mode to a column index.
// Full resolution: lane A gives 2p, lane B gives 2p+1.
// Sub-sample: p is even, so 2p starts a group of four; the offset rule picks
// the two columns, lane A always the lower one.
module col_lane_map #(
    parameter int NUM_COLS = 1280,
    localparam int PAIR_W = $clog2(NUM_COLS / 2),
    localparam int COL_W  = PAIR_W + 1
) (
    input  logic [PAIR_W-1:0]     pos_i,
    input  col_seq_pkg::lane_t    lane_i,
    input  col_seq_pkg::rd_mode_t mode_i,
    output logic [COL_W-1:0]      col_o
);
    import col_seq_pkg::*;

    logic [COL_W-1:0] base;
    logic [1:0]       off;

    // Column offset above the pair base for the current lane and mode.
    always_comb begin
        base = {pos_i, 1'b0};
        if (mode_i.sub) begin
            off = grp_offset(mode_i, lane_i);
        end else begin
            off = {1'b0, (lane_i == LANE_B)};
        end
        col_o = base + {{(COL_W-2){1'b0}}, off};
    end

endmodule

// File: rtl/col_win_ctrl.sv
// Module: window control for the column sequencer.
// Latches controls at sync, alternates lanes every clock, steps the pointer
// after lane B, counts output pixels and registers index, valid and end flag.
// Assumes sync has priority over an active window.
module col_win_ctrl #(
    parameter int NUM_COLS = 1280,
    localparam int NUM_PAIRS = NUM_COLS / 2,
    localparam int PAIR_W = $clog2(NUM_PAIRS),
    localparam int COL_W  = PAIR_W + 1,
    localparam int CNT_W  = COL_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sync_i,
    input  logic [PAIR_W-1:0]     start_i,
    input  logic [CNT_W-1:0]      width_i,
    input  col_seq_pkg::rd_mode_t mode_in,
    input  logic [PAIR_W-1:0]     pos_i,
    input  logic [COL_W-1:0]      map_col_i,
    output logic                  load_o,
    output logic [PAIR_W-1:0]     start_eff_o,
    output logic                  shift_o,
    output logic                  step2_o,
    output col_seq_pkg::lane_t    lane_o,
    output col_seq_pkg::rd_mode_t mode_o,
    output logic [COL_W-1:0]      col_o,
    output logic                  valid_o,
    output logic                  last_o
);
    import col_seq_pkg::*;

    logic              active_q;
    lane_t             lane_q;
    rd_mode_t          mode_q;
    logic [CNT_W-1:0]  width_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              start_ok;
    logic              row_end;
    logic              cnt_end;
    logic              win_end;

    // Start alignment: sub-sample mode forces an even pair.
    always_comb begin
        start_eff_o = mode_in.sub ? {start_i[PAIR_W-1:1], 1'b0} : start_i;
        start_ok    = ({1'b0, start_eff_o} < (PAIR_W+1)'(NUM_PAIRS));
    end

    // End detection: row edge on lane B, or programmed count reached.
    always_comb begin
        if (mode_q.sub) begin
            row_end = (lane_q == LANE_B) && (pos_i >= PAIR_W'(NUM_PAIRS - 2));
        end else begin
            row_end = (lane_q == LANE_B) && (pos_i == PAIR_W'(NUM_PAIRS - 1));
        end
        cnt_end = (cnt_q == width_q - 1'b1);
        win_end = row_end || cnt_end;
    end

    // Pointer commands.
    always_comb begin
        load_o  = sync_i;
        shift_o = active_q && !sync_i && (lane_q == LANE_B);
        step2_o = mode_q.sub;
        lane_o  = lane_q;
        mode_o  = mode_q;
    end

    // Window state: latch on sync, advance lanes and count while active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            lane_q   <= LANE_A;
            mode_q   <= '0;
            width_q  <= '0;
            cnt_q    <= '0;
        end else if (sync_i) begin
            active_q <= (width_i != '0) && start_ok;
            lane_q   <= LANE_A;
            mode_q   <= mode_in;
            width_q  <= width_i;
            cnt_q    <= '0;
        end else if (active_q) begin
            lane_q   <= (lane_q == LANE_A) ? LANE_B : LANE_A;
            cnt_q    <= cnt_q + 1'b1;
            if (win_end) begin
                active_q <= 1'b0;
            end
        end
    end

    // Output register: one index per clock while the window is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_o   <= '0;
            valid_o <= 1'b0;
            last_o  <= 1'b0;
        end else if (active_q && !sync_i) begin
            col_o   <= map_col_i;
            valid_o <= 1'b1;
            last_o  <= win_end;
        end else begin
            valid_o <= 1'b0;
            last_o  <= 1'b0;
        end
    end

endmodule

// File: rtl/col_subsample_seq.sv
// Top: sub-sampling column readout sequencer.
// Ties the one-hot pair pointer, the lane/mode column map and the window
// controller together. Assumes the start pair and mode are stable at sync.
module col_subsample_seq #(
    parameter int NUM_COLS = 1280,
    localparam int NUM_PAIRS = NUM_COLS / 2,
    localparam int PAIR_W = $clog2(NUM_PAIRS),
    localparam int COL_W  = PAIR_W + 1,
    localparam int CNT_W  = COL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic [PAIR_W-1:0] start_pair_i,
    input  logic [CNT_W-1:0]  width_i,
    input  logic              sub_en_i,
    input  logic              swap12_i,
    input  logic              swap30_i,
    output logic [COL_W-1:0]  col_o,
    output logic              valid_o,
    output logic              last_o
);
    import col_seq_pkg::*;

    rd_mode_t          mode_in;
    rd_mode_t          win_mode;
    lane_t             lane;
    logic [PAIR_W-1:0] pos;
    logic [PAIR_W-1:0] start_eff;
    logic [COL_W-1:0]  map_col;
    logic              ptr_load;
    logic              ptr_shift;
    logic              ptr_step2;

    // Gather the raw control inputs.
    always_comb begin
        mode_in.sub = sub_en_i;
        mode_in.s12 = swap12_i;
        mode_in.s30 = swap30_i;
    end

    col_ptr #(.NUM_PAIRS(NUM_PAIRS)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (ptr_load),
        .start_i (start_eff),
        .shift_i (ptr_shift),
        .step2_i (ptr_step2),
        .pos_o   (pos)
    );

    col_lane_map #(.NUM_COLS(NUM_COLS)) u_map (
        .pos_i  (pos),
        .lane_i (lane),
        .mode_i (win_mode),
        .col_o  (map_col)
    );

    col_win_ctrl #(.NUM_COLS(NUM_COLS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_i      (sync_i),
        .start_i     (start_pair_i),
        .width_i     (width_i),
        .mode_in     (mode_in),
        .pos_i       (pos),
        .map_col_i   (map_col),
        .load_o      (ptr_load),
        .start_eff_o (start_eff),
        .shift_o     (ptr_shift),
        .step2_o     (ptr_step2),
        .lane_o      (lane),
        .mode_o      (win_mode),
        .col_o       (col_o),
        .valid_o     (valid_o),
        .last_o      (last_o)
    );

endmodule

// File: rtl/col_seq_chk.sv
// Checker: temporal properties of the column sequencer outputs.
// Assumes it is bound into col_subsample_seq and sees the latched sub-sample bit.
module col_seq_chk #(
    parameter int NUM_COLS = 1280,
    localparam int COL_W = $clog2(NUM_COLS / 2) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_i,
    input logic             valid_o,
    input logic             last_o,
    input logic [COL_W-1:0] col_o,
    input logic             sub_q
);

    AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> !valid_o);  // R2

    AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);  // R10

    AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !valid_o);  // R10

    AST_COL_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ({1'b0, col_o} < (COL_W+1)'(NUM_COLS)));  // R11

    AST_FULL_RES_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && !sub_q) |-> (col_o == $past(col_o) + 1'b1));  // R3

    AST_SUB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && sub_q) |->
            ((col_o > $past(col_o)) && ((col_o - $past(col_o)) <= COL_W'(3))));  // R4

endmodule

bind col_subsample_seq col_seq_chk #(.NUM_COLS(NUM_COLS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_i  (sync_i),
    .valid_o (valid_o),
    .last_o  (last_o),
    .col_o   (col_o),
    .sub_q   (win_mode.sub)
);

// File: tb/test_col_subsample_seq.sv
`timescale 1ns/1ps
// Directed bench for col_subsample_seq; one task per scenario.
module test_col_subsample_seq;

    localparam int NC = 1280;
    localparam int NP = NC / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_i = 1'b0;
    logic [9:0]  start_pair_i = '0;
    logic [11:0] width_i = '0;
    logic        sub_en_i = 1'b0;
    logic        swap12_i = 1'b0;
    logic        swap30_i = 1'b0;
    logic [10:0] col_o;
    logic        valid_o;
    logic        last_o;

    int n_chk = 0;
    int n_fail = 0;
    int exp_col [0:NC-1];

    always #2.5 clk = ~clk;

    col_subsample_seq i_col_subsample_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_i       (sync_i),
        .start_pair_i (start_pair_i),
        .width_i      (width_i),
        .sub_en_i     (sub_en_i),
        .swap12_i     (swap12_i),
        .swap30_i     (swap30_i),
        .col_o        (col_o),
        .valid_o      (valid_o),
        .last_o       (last_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference: is offset off (0..3) in a group read for this swap setting.
    function automatic bit keep(int off, bit s12, bit s30);
        if (!s12 && !s30) return off == 0 || off == 1;
        if (s12 && !s30)  return off == 0 || off == 2;
        if (!s12 && s30)  return off == 1 || off == 3;
        return off == 2 || off == 3;
    endfunction

    // Build the expected index list; returns its length.
    function automatic int build(int start, int width, bit sub, bit s12, bit s30);
        int n = 0;
        int s = sub ? (start & ~1) : start;
        if (width == 0 || s >= NP) return 0;
        for (int c = 2 * s; c < NC; c++) begin
            if (n < width && (!sub || keep(c % 4, s12, s30))) begin
                exp_col[n] = c;
                n++;
            end
        end
        return n;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(valid_o == 1'b0, "R1", "valid in reset", int'(valid_o), 0);
        chk(last_o == 1'b0, "R1", "last in reset", int'(last_o), 0);
        chk(col_o == '0, "R1", "col in reset", int'(col_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid_o == 1'b0, "R1", "valid after reset", int'(valid_o), 0);
    endtask

    // Run one window and compare every output cycle; scramble alters inputs after sync.
    task automatic t_window(input string req, input int start, input int width,
                            input bit sub, input bit s12, input bit s30, input bit scramble);
        int n = build(start, width, sub, s12, s30);
        start_pair_i = 10'(start);
        width_i      = 12'(width);
        sub_en_i     = sub;
        swap12_i     = s12;
        swap30_i     = s30;
        sync_i       = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(valid_o == 1'b0, "R2", "valid during sync", int'(valid_o), 0);
        end
        sync_i = 1'b0;
        if (scramble) begin
            start_pair_i = 10'(start + 3);
            width_i      = 12'(width + 5);
            sub_en_i     = ~sub;
            swap12_i     = ~s12;
            swap30_i     = ~s30;
        end
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(valid_o == 1'b1, req, "valid", int'(valid_o), 1);
            chk(int'(col_o) == exp_col[k], req, "col", int'(col_o), exp_col[k]);
            chk(last_o == (k == n - 1), req, "last", int'(last_o), int'(k == n - 1));
        end
        repeat (6) begin
            @(negedge clk);
            chk(valid_o == 1'b0, (n == 0) ? "R12" : "R10", "idle valid", int'(valid_o), 0);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_window("R3", 0, 16, 0, 0, 0, 0);
        t_window("R3", 5, 7, 0, 0, 0, 0);
        t_window("R8", 4, 24, 0, 1, 0, 0);
        t_window("R8", 4, 24, 0, 0, 1, 0);
        t_window("R8", 4, 24, 0, 1, 1, 0);
        t_window("R4", 4, 24, 1, 0, 0, 0);
        t_window("R5", 4, 24, 1, 1, 0, 0);
        t_window("R6", 4, 24, 1, 0, 1, 0);
        t_window("R7", 4, 24, 1, 1, 1, 0);
        t_window("R9", 7, 10, 1, 1, 0, 0);
        t_window("R9", 9, 6, 1, 0, 1, 0);
        t_window("R10", 100, 1, 0, 0, 0, 0);
        t_window("R10", 0, 640, 1, 0, 0, 0);
        t_window("R11", 630, 100, 0, 0, 0, 0);
        t_window("R11", 636, 50, 1, 1, 1, 0);
        t_window("R11", 0, 1280, 0, 0, 0, 0);
        t_window("R12", 10, 0, 0, 0, 0, 0);
        t_window("R12", 700, 20, 0, 0, 0, 0);
        t_window("R13", 20, 30, 1, 0, 1, 1);
        t_window("R13", 3, 9, 0, 1, 1, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule